// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming Ethernet frame is kept or discarded. It looks only at the destination address, which arrives one byte per clock, first byte first. It also looks at the frame length, which is supplied once the frame has ended. The result is a single accept bit, qualified by a one-cycle valid pulse. The surrounding receive path uses that pulse to commit or drop the frame it has already buffered.

Three kinds of destination are handled differently:

- **Broadcast.** An address of all-ones is governed by its own reject control.
- **Group addresses, or any address when hash-all mode is on.** These are checked against a 64-entry hash bitmap. The bitmap is indexed by a bit-serial CRC, which is folded in as the bytes arrive.
- **Individual addresses.** These are compared against the programmed 48-bit station address.

A promiscuous control overrides any address miss. A minimum-length check rejects short frames unless the short-frame control is set.

Top module: `rx_da_filter`

## Requirements
- R1: After reset, `res_valid` and `res_accept` are both 0.
- R2: A destination whose six bytes are all 0xFF is broadcast. It misses when `cfg_bcast_rej` is 1 and hits when it is 0. This holds regardless of the hash and station settings.
- R3: A non-broadcast destination goes through the hash lookup when bit 0 of its first byte is 1, or when `cfg_hash_all` is 1. In that case the station compare is not used.
- R4: The hash CRC register is 32 bits and is seeded with 0xFFFFFFFF at the first byte. It consumes the six bytes in arrival order, bit 0 of each byte first. For each bit:
  - The feedback is register bit 31 XOR the data bit.
  - The register shifts left by one.
  - When the feedback is 1, the register is XORed with 0x04C11DB6 and bit 0 is then set to 1.
  - The hash index is bits 31:26 of the final register.
- R5: A hash index of 32 or more selects bit (index−32) of `cfg_hash_hi`; a smaller index selects bit (index) of `cfg_hash_lo`. A selected bit of 0 is a miss.
- R6: An individual destination hits only if all six bytes match the station address. Byte 0 is compared with `cfg_station_hi[15:8]` and byte 1 with `cfg_station_hi[7:0]`. Bytes 2, 3, 4 and 5 are compared with `cfg_station_lo` bits 31:24, 23:16, 15:8 and 7:0.
- R7: An address miss rejects the frame unless `cfg_promisc` is 1.
- R8: A frame with `len_bytes` below `cfg_min_len` is rejected unless `cfg_small_ok` is 1. A length equal to the minimum passes.
- R9: `byte_start` together with `byte_valid` restarts address collection. Bytes after the sixth have no effect. A length presented before six bytes have been collected is rejected.
- R10: `res_valid` pulses for exactly one cycle, on the cycle after `len_valid`. `len_valid` may share a cycle with the sixth address byte, and that byte is then included in the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bcast_rej | input | 1 | Treat broadcast as a miss |
| cfg_promisc | input | 1 | Accept despite an address miss |
| cfg_hash_all | input | 1 | Use hash lookup for every non-broadcast address |
| cfg_small_ok | input | 1 | Accept frames shorter than the minimum |
| cfg_station_hi | input | 16 | Station address bytes 0 (15:8) and 1 (7:0) |
| cfg_station_lo | input | 32 | Station address bytes 2 (31:24) to 5 (7:0) |
| cfg_hash_lo | input | 32 | Hash bitmap entries 0 to 31 |
| cfg_hash_hi | input | 32 | Hash bitmap entries 32 to 63 |
| cfg_min_len | input | 16 | Minimum accepted frame length in bytes |
| byte_valid | input | 1 | An address byte is present |
| byte_start | input | 1 | The present byte is the first of a frame |
| byte_data | input | 8 | Address byte |
| len_valid | input | 1 | Frame length is present; requests a decision |
| len_bytes | input | 16 | Frame length in bytes |
| res_valid | output | 1 | Decision pulse |
| res_accept | output | 1 | 1 = keep frame, 0 = drop |

## Verification
The collision of interest is the sixth address byte and the length request arriving in the same cycle. In that cycle the decision must be taken from the address state that is being updated, not from the registered state that still lacks the final byte.

The bench provokes this with frames whose outcome depends only on that last byte:
- a station address that matches only through byte 5;
- a group address whose hash bit is set only for the complete six-byte CRC.

Each such frame is sent once with the length one cycle late and once in the same cycle. Both runs are judged against the same expected verdict. A wrongly staged design would reject the same-cycle copy.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;
    localparam int CRC_W = 32;
    localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB6;
    localparam int ADDR_BYTES = 6;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = ADDR_BYTES * BYTE_W;
endpackage

// File: rtl/dafilt_crc_step.sv
module dafilt_crc_step
    import dafilt_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);
    logic [CRC_W-1:0] chain [0:DATA_W];

    assign chain[0] = crc_in;

    // one stage per data bit, least significant bit consumed first
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        logic             fb;
        logic [CRC_W-1:0] shifted;
        assign fb      = chain[b][CRC_W-1] ^ data_in[b];
        assign shifted = {chain[b][CRC_W-2:0], 1'b0};
        assign chain[b+1] = fb ? ((shifted ^ CRC_POLY) | {{(CRC_W-1){1'b0}}, 1'b1})
                               : shifted;
    end

    assign crc_out = chain[DATA_W];
endmodule

// File: rtl/dafilt_byte_cmp.sv
module dafilt_byte_cmp
    import dafilt_pkg::*;
#(
    parameter int POS_W = 3
) (
    input  logic [POS_W-1:0]  pos,
    input  logic [BYTE_W-1:0] data_in,
    input  logic [ADDR_W-1:0] station,
    output logic              eq,
    output logic              is_ones
);
    logic [BYTE_W-1:0] ref_byte;

    // byte 0 of the station sits in the most significant lane
    always_comb begin
        ref_byte = '0;
        for (int k = 0; k < ADDR_BYTES; k++) begin
            if (pos == POS_W'(k)) begin
                ref_byte = station[ADDR_W-BYTE_W*(k+1) +: BYTE_W];
            end
        end
    end

    assign eq      = (data_in == ref_byte);
    assign is_ones = &data_in;
endmodule

// File: rtl/dafilt_verdict.sv
module dafilt_verdict #(
    parameter int LEN_W  = 16,
    parameter int IDX_W  = 6
) (
    input  logic               complete,
    input  logic               all_ones,
    input  logic               all_eq,
    input  logic               grp,
    input  logic [IDX_W-1:0]   hash_idx,
    input  logic [(1<<IDX_W)-1:0] hash_tbl,
    input  logic               bcast_rej,
    input  logic               promisc,
    input  logic               hash_all,
    input  logic               small_ok,
    input  logic [LEN_W-1:0]   len,
    input  logic [LEN_W-1:0]   min_len,
    output logic               accept
);
    logic miss;
    logic len_ok;

    // broadcast outranks the hash path, which outranks the station compare
    always_comb begin
        if (all_ones)              miss = bcast_rej;
        else if (grp || hash_all)  miss = !hash_tbl[hash_idx];
        else                       miss = !all_eq;
    end

    assign len_ok = small_ok || (len >= min_len);
    assign accept = complete && (!miss || promisc) && len_ok;
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
    import dafilt_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int STA_HI_W   = 16,
    parameter int HASH_REG_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_bcast_rej,
    input  logic                  cfg_promisc,
    input  logic                  cfg_hash_all,
    input  logic                  cfg_small_ok,
    input  logic [STA_HI_W-1:0]   cfg_station_hi,
    input  logic [ADDR_W-STA_HI_W-1:0] cfg_station_lo,
    input  logic [HASH_REG_W-1:0] cfg_hash_lo,
    input  logic [HASH_REG_W-1:0] cfg_hash_hi,
    input  logic [LEN_W-1:0]      cfg_min_len,
    input  logic                  byte_valid,
    input  logic                  byte_start,
    input  logic [BYTE_W-1:0]     byte_data,
    input  logic                  len_valid,
    input  logic [LEN_W-1:0]      len_bytes,
    output logic                  res_valid,
    output logic                  res_accept
);
    localparam int CNT_W  = $clog2(ADDR_BYTES + 1);
    localparam int IDX_W  = $clog2(2 * HASH_REG_W);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_BYTES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CRC_W-1:0] crc;
        logic             all_ones;
        logic             all_eq;
        logic             grp;
    } addr_t;

    typedef struct packed {
        addr_t addr;
        logic  res_valid;
        logic  res_accept;
    } state_t;

    localparam addr_t ADDR_INIT = '{cnt: '0, crc: CRC_SEED, all_ones: 1'b1,
                                    all_eq: 1'b1, grp: 1'b0};
    localparam state_t STATE_RST = '{addr: ADDR_INIT, res_valid: 1'b0, res_accept: 1'b0};

    state_t s_q, s_d;
    addr_t  base_d, addr_d;
    logic [CRC_W-1:0] crc_next_d;
    logic   eq_d, ones_d, take_d, accept_d;

    // starting point for this cycle's byte: fresh on a start strobe
    always_comb begin
        base_d = (byte_valid && byte_start) ? ADDR_INIT : s_q.addr;
        take_d = byte_valid && (byte_start || (s_q.addr.cnt < CNT_FULL));
    end

    dafilt_crc_step #(.DATA_W(BYTE_W)) u_crc (
        .crc_in  (base_d.crc),
        .data_in (byte_data),
        .crc_out (crc_next_d)
    );

    dafilt_byte_cmp #(.POS_W(CNT_W)) u_cmp (
        .pos     (base_d.cnt),
        .data_in (byte_data),
        .station ({cfg_station_hi, cfg_station_lo}),
        .eq      (eq_d),
        .is_ones (ones_d)
    );

    always_comb begin
        addr_d = base_d;
        if (take_d) begin
            addr_d.cnt      = base_d.cnt + 1'b1;
            addr_d.crc      = crc_next_d;
            addr_d.all_ones = base_d.all_ones && ones_d;
            addr_d.all_eq   = base_d.all_eq && eq_d;
            if (base_d.cnt == '0) addr_d.grp = byte_data[0];
        end
    end

    dafilt_verdict #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_verdict (
        .complete  (addr_d.cnt == CNT_FULL),
        .all_ones  (addr_d.all_ones),
        .all_eq    (addr_d.all_eq),
        .grp       (addr_d.grp),
        .hash_idx  (addr_d.crc[CRC_W-1 -: IDX_W]),
        .hash_tbl  ({cfg_hash_hi, cfg_hash_lo}),
        .bcast_rej (cfg_bcast_rej),
        .promisc   (cfg_promisc),
        .hash_all  (cfg_hash_all),
        .small_ok  (cfg_small_ok),
        .len       (len_bytes),
        .min_len   (cfg_min_len),
        .accept    (accept_d)
    );

    always_comb begin
        s_d            = s_q;
        s_d.addr       = addr_d;
        s_d.res_valid  = len_valid;
        s_d.res_accept = len_valid && accept_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= STATE_RST;
        else        s_q <= s_d;
    end

    assign res_valid  = s_q.res_valid;
    assign res_accept = s_q.res_accept;

    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        len_valid |=> res_valid);
    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !len_valid |=> !res_valid);
    p_accept_qualified_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_accept |-> res_valid);
    p_short_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_accept) |-> $past(cfg_small_ok || (len_bytes >= cfg_min_len)));
    p_cnt_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.addr.cnt <= CNT_FULL);
    p_bcast_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (len_valid && cfg_bcast_rej && !cfg_promisc && addr_d.all_ones) |=> !res_accept);
endmodule

// File: tb/rx_da_filter_tb.sv
`timescale 1ns/1ps
module rx_da_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_bcast_rej = 1'b0, cfg_promisc = 1'b0, cfg_hash_all = 1'b0, cfg_small_ok = 1'b0;
    logic [15:0] cfg_station_hi = 16'h0211;
    logic [31:0] cfg_station_lo = 32'h2233_4455;
    logic [31:0] cfg_hash_lo = '0, cfg_hash_hi = '0;
    logic [15:0] cfg_min_len = 16'd64;
    logic        byte_valid = 1'b0, byte_start = 1'b0, len_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic [15:0] len_bytes = '0;
    logic        res_valid, res_accept;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    localparam logic [47:0] STATION = 48'h0211_2233_4455;

    always #2.5 clk = ~clk;

    rx_da_filter u_dut (
        .clk, .rst_n, .cfg_bcast_rej, .cfg_promisc, .cfg_hash_all, .cfg_small_ok,
        .cfg_station_hi, .cfg_station_lo, .cfg_hash_lo, .cfg_hash_hi, .cfg_min_len,
        .byte_valid, .byte_start, .byte_data, .len_valid, .len_bytes,
        .res_valid, .res_accept
    );

    task automatic chk(input logic got, input logic exp, input string what);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0b exp=%0b", what, got, exp);
        end
    endtask

    function automatic logic [5:0] hash_of(input logic [47:0] da);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] b = da[47-8*i -: 8];
            for (int j = 0; j < 8; j++) begin
                logic fb = c[31] ^ b[j];
                c = {c[30:0], 1'b0};
                if (fb) c = (c ^ 32'h04C1_1DB6) | 32'd1;
            end
        end
        return c[31:26];
    endfunction

    task automatic set_hash_bit(input logic [5:0] idx);
        cfg_hash_lo = '0; cfg_hash_hi = '0;
        if (idx[5]) cfg_hash_hi[idx[4:0]] = 1'b1;
        else        cfg_hash_lo[idx[4:0]] = 1'b1;
    endtask

    // sends nbytes of da, optional extra byte, then the length; returns verdict
    task automatic frame(input logic [47:0] da, input int nbytes, input bit same,
                         input bit extra, input logic [15:0] len,
                         input string tag, output logic acc);
        for (int i = 0; i < nbytes; i++) begin
            @(negedge clk);
            byte_valid = 1'b1; byte_start = (i == 0); byte_data = da[47-8*i -: 8];
            if (same && i == nbytes - 1) begin len_valid = 1'b1; len_bytes = len; end
        end
        if (extra) begin
            @(negedge clk);
            byte_valid = 1'b1; byte_start = 1'b0; byte_data = ~da[7:0];
        end
        if (!same) begin
            @(negedge clk);
            byte_valid = 1'b0; byte_start = 1'b0;
            len_valid = 1'b1; len_bytes = len;
        end
        @(posedge clk); #1;
        chk(res_valid, 1'b1, {tag, " R10 valid after length"});
        acc = res_accept;
        @(negedge clk);
        byte_valid = 1'b0; byte_start = 1'b0; len_valid = 1'b0;
        @(posedge clk); #1;
        chk(res_valid, 1'b0, {tag, " R10 single-cycle pulse"});
    endtask

    task automatic t_reset();
        chk(res_valid, 1'b0, "R1 valid at reset");
        chk(res_accept, 1'b0, "R1 accept at reset");
    endtask

    task automatic t_unicast();
        logic a;
        frame(STATION, 6, 0, 0, 16'd100, "R6", a); chk(a, 1'b1, "R6 station match");
        frame(STATION ^ 48'h1, 6, 0, 0, 16'd100, "R6", a); chk(a, 1'b0, "R6 last byte differs");
        frame(STATION ^ 48'h0200_0000_0000, 6, 0, 0, 16'd100, "R6", a); chk(a, 1'b0, "R6 byte0 differs");
        frame(STATION ^ 48'h0000_0100_0000, 6, 0, 0, 16'd100, "R6", a); chk(a, 1'b0, "R6 byte2 differs");
        cfg_promisc = 1'b1;
        frame(STATION ^ 48'h1, 6, 0, 0, 16'd100, "R7", a); chk(a, 1'b1, "R7 promiscuous overrides miss");
        cfg_promisc = 1'b0;
    endtask

    task automatic t_bcast();
        logic a;
        cfg_hash_all = 1'b1;
        frame(48'hFFFF_FFFF_FFFF, 6, 0, 0, 16'd80, "R2", a); chk(a, 1'b1, "R2 broadcast allowed");
        cfg_bcast_rej = 1'b1;
        frame(48'hFFFF_FFFF_FFFF, 6, 0, 0, 16'd80, "R2", a); chk(a, 1'b0, "R2 broadcast rejected");
        cfg_promisc = 1'b1;
        frame(48'hFFFF_FFFF_FFFF, 6, 0, 0, 16'd80, "R7", a); chk(a, 1'b1, "R7 promiscuous over broadcast reject");
        cfg_promisc = 1'b0; cfg_bcast_rej = 1'b0; cfg_hash_all = 1'b0;
    endtask

    task automatic t_hash();
        logic a;
        logic [47:0] m1 = 48'h0100_5E00_0001, m2 = m1;
        logic [5:0]  i1 = hash_of(m1), i2;
        set_hash_bit(i1);
        frame(m1, 6, 0, 0, 16'd70, "R4", a); chk(a, 1'b1, "R4/R5 hash bit set");
        cfg_hash_lo = ~cfg_hash_lo; cfg_hash_hi = ~cfg_hash_hi;
        frame(m1, 6, 0, 0, 16'd70, "R5", a); chk(a, 1'b0, "R5 only the indexed bit clear");
        for (int k = 0; k < 256; k++) begin
            m2[7:0] = 8'(k);
            if (hash_of(m2)[5] != i1[5]) break;
        end
        i2 = hash_of(m2);
        set_hash_bit(i2);
        frame(m2, 6, 0, 0, 16'd70, "R5", a); chk(a, 1'b1, "R5 other register selected");
        set_hash_bit(i2 ^ 6'h20);
        frame(m2, 6, 0, 0, 16'd70, "R5", a); chk(a, 1'b0, "R5 wrong register half");
        // R3: station match is ignored in hash-all mode
        cfg_hash_all = 1'b1;
        set_hash_bit(~hash_of(STATION));
        frame(STATION, 6, 0, 0, 16'd70, "R3", a); chk(a, 1'b0, "R3 hash-all bypasses station");
        set_hash_bit(hash_of(STATION));
        frame(STATION, 6, 0, 0, 16'd70, "R3", a); chk(a, 1'b1, "R3 hash-all hit");
        cfg_hash_all = 1'b0;
        // R3: group bit with station match still uses hash
        set_hash_bit(~hash_of(48'h0311_2233_4455));
        cfg_station_hi = 16'h0311;
        frame(48'h0311_2233_4455, 6, 0, 0, 16'd70, "R3", a); chk(a, 1'b0, "R3 group bit forces hash");
        cfg_station_hi = 16'h0211;
        // same-cycle length with hash depending on final byte
        set_hash_bit(i1);
        frame(m1, 6, 1, 0, 16'd70, "R10", a); chk(a, 1'b1, "R10 length with last byte, hash");
        cfg_hash_lo = '0; cfg_hash_hi = '0;
    endtask

    task automatic t_length();
        logic a;
        frame(STATION, 6, 0, 0, 16'd63, "R8", a); chk(a, 1'b0, "R8 one below minimum");
        frame(STATION, 6, 0, 0, 16'd64, "R8", a); chk(a, 1'b1, "R8 equal to minimum");
        cfg_small_ok = 1'b1;
        frame(STATION, 6, 0, 0, 16'd10, "R8", a); chk(a, 1'b1, "R8 short allowed");
        cfg_small_ok = 1'b0;
    endtask

    task automatic t_sequence();
        logic a;
        frame(STATION, 6, 1, 0, 16'd100, "R10", a); chk(a, 1'b1, "R10 length with last byte, station");
        frame(STATION, 6, 0, 1, 16'd100, "R9", a); chk(a, 1'b1, "R9 seventh byte ignored");
        frame(STATION, 5, 0, 0, 16'd100, "R9", a); chk(a, 1'b0, "R9 incomplete address rejected");
        frame(STATION, 6, 0, 0, 16'd100, "R9", a); chk(a, 1'b1, "R9 start strobe restarts");
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #1; t_reset();
        #11; rst_n = 1'b1;
        @(negedge clk); @(posedge clk); #1;
        t_reset();
        t_unicast();
        t_bcast();
        t_hash();
        t_length();
        t_sequence();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule